// File: doc/BRIEF.md
# Linked-descriptor receive DMA channel

The block is one receive DMA channel. It accepts a byte stream of frames, each frame closed by a last flag, and stores the bytes in memory. The destination buffers are found by walking a chain of control blocks in a word-addressed memory. Each control block holds a link to the next block, a word that gives the byte capacity of every buffer, and a set of (buffer address, status) word pairs. When a buffer is closed, the channel writes its status word back. That word carries the byte count, frame-boundary flags, an interrupt flag and a completion flag.

Software builds the chain, loads the head address through two 32-bit registers, sets how many buffer pairs each block uses, and then activates the channel. A link value of 1 ends the chain, and the channel parks there. To extend the chain, software appends blocks, rewrites the old terminating link, and strobes reload. The channel then re-reads that link and carries on.

A sticky interrupt line reports closed buffers. It can be limited to buffers that end a frame. The memory port carries one request per cycle. A write completes in the cycle it is issued. A read returns one data word on a later cycle flagged by a valid strobe, and only one read is outstanding at a time.

Top module: `rx_chain_dma`

## Requirements
- R1: After reset, s_ready_o, mem_req_o and irq_o are all low.
- R2: Activation starts the walk at the head address (register 0 holds the low word, register 1 the high word). In a block at word address D: D+1 holds the buffer capacity in bits 15:0, D+2+2k holds the address of buffer k, D+3+2k holds its status word, and D+0 holds the link. The link is read only after the last buffer pair of the block.
- R3: Bytes are stored little-endian in 32-bit words from the buffer address upward. Byte n goes to word n/4, lane n%4. Unused upper bytes of a buffer's last word are written as zero.
- R4: When a buffer closes, its status word is written as follows: byte count in bits 15:0, start-of-frame at bit 16, end-of-frame at bit 17, interrupt at bit 18, done (always 1) at bit 19, and zero in bits 31:20.
- R5: A buffer closes when it is full or when the frame's last byte arrives. A frame longer than one buffer continues in the next buffer. Start-of-frame is set only in a frame's first buffer and end-of-frame only in its last. The buffer after an end-of-frame begins a new frame.
- R6: A link value of 0x1 parks the channel. While parked, it issues no memory request and holds s_ready_o low.
- R7: Writing bit 1 of register 3 while parked re-reads the link of the last block. If the link is now valid, the walk continues at that block.
- R8: Register 2 bits 3:0 set the number of buffer pairs used per block.
- R9: When register 2 bit 8 is set, the interrupt flag (and the interrupt request) is raised only for buffers holding an end-of-frame. When it is clear, every closed buffer raises it.
- R10: irq_o is sticky. It is set by a raised buffer interrupt and cleared by writing 1 to bit 0 of register 4. A set in the same cycle wins over the clear.
- R11: Register 3 bit 0 is the activate level. Writing it to 0 stops the walk after the current buffer's status write, and no further block is fetched. A channel still waiting for a buffer's first byte stops at once and holds s_ready_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Last byte of frame |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Sticky buffer interrupt |

## Verification
Some properties are checked on every cycle by the assertions:
- entering the parked state on a terminating link silences memory and stream;
- a reload while parked issues a read of exactly the last block's link address;
- a deactivated channel goes quiet right after a status write;
- the interrupt line is sticky;
- every word starts from an empty packer.

Other behaviour can only be shown by the bench's scenarios. These cover the stored bytes and their zero fill, the status encoding across frames of one byte, exactly one buffer and more than one buffer, the placement of start and end flags, the per-block buffer count, and both interrupt modes observed at irq_o. They also cover resuming after the chain is extended.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;
  localparam logic [31:0] LIST_END = 32'h1;

  localparam logic [2:0] REG_HEAD_LO = 3'd0;
  localparam logic [2:0] REG_HEAD_HI = 3'd1;
  localparam logic [2:0] REG_CFG     = 3'd2;
  localparam logic [2:0] REG_CTRL    = 3'd3;
  localparam logic [2:0] REG_IRQ_CLR = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INFO, ST_DPTR, ST_FILL, ST_STAT, ST_NEXT, ST_PARK
  } walk_st_e;

  typedef struct packed {
    logic             eof_only;
    logic [CNT_W-1:0] cnt;
  } ch_cfg_t;

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input logic sof, input logic eof,
                                              input logic intr);
    return {12'h000, 1'b1, intr, eof, sof, len};
  endfunction
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              irq_set_i,
  output logic [ADDR_W-1:0] head_o,
  output ch_cfg_t           cfg_o,
  output logic              active_o,
  output logic              reload_o,
  output logic              irq_o
);
  logic [31:0] head_lo_q, head_hi_q;
  logic [63:0] head_full;
  logic        irq_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_lo_q <= '0;
      head_hi_q <= '0;
      cfg_o     <= '{eof_only: 1'b0, cnt: CNT_W'(1)};
      active_o  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == REG_HEAD_LO) head_lo_q <= wdata_i;
      if (addr_i == REG_HEAD_HI) head_hi_q <= wdata_i;
      if (addr_i == REG_CFG)     cfg_o <= '{eof_only: wdata_i[8], cnt: wdata_i[CNT_W-1:0]};
      if (addr_i == REG_CTRL)    active_o <= wdata_i[0];
    end
  end

  assign irq_clr  = we_i && (addr_i == REG_IRQ_CLR) && wdata_i[0];
  assign reload_o = we_i && (addr_i == REG_CTRL) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (irq_set_i) irq_o <= 1'b1;
    else if (irq_clr)   irq_o <= 1'b0;
  end

  assign head_full = {head_hi_q, head_lo_q};
  assign head_o    = head_full[ADDR_W-1:0];

  if (ADDR_W < 64) begin : g_trim
    logic unused_head;
    assign unused_head = ^head_full[63:ADDR_W];
  end

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o);
endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        flush_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  logic [31:0] word_q;

  always_comb begin
    word_o = word_q;
    word_o[{lane_i, 3'b000} +: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (push_i) word_q <= flush_i ? 32'h0 : word_o;
  end

  // R3
  lane0_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && lane_i == 2'd0) |-> (word_q == 32'h0));
endmodule

// File: rtl/rxdma_walker.sv
module rxdma_walker
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              reload_i,
  input  logic [ADDR_W-1:0] head_i,
  input  ch_cfg_t           cfg_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              pk_push_o,
  output logic [1:0]        pk_lane_o,
  output logic              pk_flush_o,
  input  logic [31:0]       pk_word_i,
  output logic              irq_set_o
);
  walk_st_e          state_q;
  logic [ADDR_W-1:0] dcb_q, dptr_q, pair_base;
  logic [LEN_W-1:0]  buf_len_q, bcnt_q, bnext;
  logic [CNT_W-1:0]  k_q, last_k;
  logic              pend_q, sof_q, eof_q;
  logic              take, buf_end, intr, rsp;

  assign last_k    = (cfg_i.cnt == '0) ? '0 : cfg_i.cnt - CNT_W'(1);
  assign pair_base = dcb_q + ADDR_W'({k_q, 1'b0}) + ADDR_W'(2);
  assign bnext     = bcnt_q + LEN_W'(1);
  assign take      = s_valid_i && s_ready_o;
  assign buf_end   = s_last_i || (bnext == buf_len_q);
  assign intr      = !cfg_i.eof_only || eof_q;
  assign rsp       = pend_q && mem_rvalid_i;
  assign pk_lane_o = bcnt_q[1:0];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    s_ready_o   = 1'b0;
    pk_push_o   = 1'b0;
    pk_flush_o  = 1'b0;
    irq_set_o   = 1'b0;
    case (state_q)
      ST_INFO: begin mem_req_o = !pend_q; mem_addr_o = dcb_q + ADDR_W'(1); end
      ST_DPTR: begin mem_req_o = !pend_q; mem_addr_o = pair_base; end
      ST_NEXT: begin mem_req_o = !pend_q; mem_addr_o = dcb_q; end
      ST_FILL: begin
        s_ready_o = active_i || (bcnt_q != '0);
        if (take) begin
          pk_push_o   = 1'b1;
          pk_flush_o  = (bcnt_q[1:0] == 2'd3) || buf_end;
          mem_req_o   = pk_flush_o;
          mem_we_o    = pk_flush_o;
          mem_addr_o  = dptr_q + ADDR_W'(bcnt_q[LEN_W-1:2]);
          mem_wdata_o = pk_word_i;
        end
      end
      ST_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pair_base + ADDR_W'(1);
        mem_wdata_o = pack_status(bcnt_q, sof_q, eof_q, intr);
        irq_set_o   = intr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dcb_q     <= '0;
      dptr_q    <= '0;
      buf_len_q <= '0;
      bcnt_q    <= '0;
      k_q       <= '0;
      pend_q    <= 1'b0;
      sof_q     <= 1'b1;
      eof_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (active_i) begin
          dcb_q   <= head_i;
          sof_q   <= 1'b1;
          pend_q  <= 1'b0;
          state_q <= ST_INFO;
        end
        ST_INFO: begin
          if (!pend_q) pend_q <= 1'b1;
          else if (rsp) begin
            pend_q    <= 1'b0;
            buf_len_q <= mem_rdata_i[LEN_W-1:0];
            k_q       <= '0;
            state_q   <= ST_DPTR;
          end
        end
        ST_DPTR: begin
          if (!pend_q) pend_q <= 1'b1;
          else if (rsp) begin
            pend_q  <= 1'b0;
            dptr_q  <= ADDR_W'(mem_rdata_i);
            bcnt_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (bcnt_q == '0 && !active_i) state_q <= ST_IDLE;
          else if (take) begin
            bcnt_q <= bnext;
            if (buf_end) begin
              eof_q   <= s_last_i;
              state_q <= ST_STAT;
            end
          end
        end
        ST_STAT: begin
          sof_q <= eof_q;
          if (!active_i)         state_q <= ST_IDLE;
          else if (k_q == last_k) state_q <= ST_NEXT;
          else begin
            k_q     <= k_q + CNT_W'(1);
            state_q <= ST_DPTR;
          end
        end
        ST_NEXT: begin
          if (!pend_q) pend_q <= 1'b1;
          else if (rsp) begin
            pend_q <= 1'b0;
            if (mem_rdata_i == LIST_END) state_q <= ST_PARK;
            else begin
              dcb_q   <= ADDR_W'(mem_rdata_i);
              state_q <= ST_INFO;
            end
          end
        end
        ST_PARK: begin
          if (!active_i)     state_q <= ST_IDLE;
          else if (reload_i) state_q <= ST_NEXT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  park_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEXT && rsp && mem_rdata_i == LIST_END) |=> (!mem_req_o && !s_ready_o));
  // R7
  reload_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK && active_i && reload_i) |=>
      (mem_req_o && !mem_we_o && mem_addr_o == $past(dcb_q)));
  // R11
  stop_after_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAT && !active_i) |=> (!mem_req_o && !s_ready_o));
endmodule

// File: rtl/rx_chain_dma.sv
module rx_chain_dma
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o
);
  logic [ADDR_W-1:0] head;
  ch_cfg_t           cfg;
  logic              active, reload, irq_set;
  logic              pk_push, pk_flush;
  logic [1:0]        pk_lane;
  logic [31:0]       pk_word;

  rxdma_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .irq_set_i (irq_set),
    .head_o    (head),
    .cfg_o     (cfg),
    .active_o  (active),
    .reload_o  (reload),
    .irq_o     (irq_o)
  );

  rxdma_packer i_packer (
    .clk_i, .rst_ni,
    .push_i  (pk_push),
    .flush_i (pk_flush),
    .lane_i  (pk_lane),
    .byte_i  (s_data_i),
    .word_o  (pk_word)
  );

  rxdma_walker #(.ADDR_W(ADDR_W)) i_walker (
    .clk_i, .rst_ni,
    .active_i     (active),
    .reload_i     (reload),
    .head_i       (head),
    .cfg_i        (cfg),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .s_valid_i    (s_valid_i),
    .s_last_i     (s_last_i),
    .s_ready_o    (s_ready_o),
    .pk_push_o    (pk_push),
    .pk_lane_o    (pk_lane),
    .pk_flush_o   (pk_flush),
    .pk_word_i    (pk_word),
    .irq_set_o    (irq_set)
  );
endmodule

// File: tb/test_rx_chain_dma.sv
module test_rx_chain_dma;
  localparam int ADDR_W = 40;
  // frame length, buffers it occupies (capacity 8)
  localparam int VEC [6][2] = '{'{3, 1}, '{8, 1}, '{10, 2}, '{1, 1}, '{12, 2}, '{4, 1}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic              reg_we_i = 1'b0;
  logic [2:0]        reg_addr_i = 3'd0;
  logic [31:0]       reg_wdata_i = 32'h0;
  logic              s_valid_i = 1'b0;
  logic [7:0]        s_data_i = 8'h0;
  logic              s_last_i = 1'b0;
  logic              s_ready_o, mem_req_o, mem_we_o, irq_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0]       mem_wdata_o;
  logic              mem_rvalid_i = 1'b0;
  logic [31:0]       mem_rdata_i = 32'h0;

  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_addr = 10'd0;
  logic [31:0] tb_wdata = 32'h0;

  int checks = 0;
  int errors = 0;

  rx_chain_dma #(.ADDR_W(ADDR_W)) i_rx_chain_dma (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .s_valid_i, .s_data_i, .s_last_i, .s_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .irq_o
  );

  always @(posedge clk) begin
    mem_rvalid_i <= mem_req_o && !mem_we_o;
    mem_rdata_i  <= mem[mem_addr_o[9:0]];
    if (mem_req_o && mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
    else if (tb_we)            mem[tb_addr] <= tb_wdata;
  end

  function automatic logic [7:0] bval(input int seed, input int j);
    return 8'((seed * 37 + j + 1) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 10'(a); tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic send_bytes(input int seed, input int first, input int n, input logic last);
    for (int j = first; j < first + n; j++) begin
      @(negedge clk);
      s_valid_i = 1'b1;
      s_data_i  = bval(seed, j);
      s_last_i  = last && (j == first + n - 1);
      while (!s_ready_o) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  task automatic check_buf(input string tag, input int st_a, input int d_a, input int seed,
                           input int first, input int len,
                           input logic sof, input logic eof, input logic intr);
    logic [31:0] exp;
    chk({tag, " status"}, mem[10'(st_a)], {12'h000, 1'b1, intr, eof, sof, 16'(len)});
    for (int w = 0; w < (len + 3) / 4; w++) begin
      exp = 32'h0;
      for (int i = 0; i < 4; i++)
        if (4 * w + i < len) exp[8 * i +: 8] = bval(seed, first + 4 * w + i);
      chk({tag, " data"}, mem[10'(d_a + w)], exp);
    end
  endtask

  task automatic idle_probe(input string tag);
    logic seen;
    seen = 1'b0;
    @(negedge clk);
    s_valid_i = 1'b1; s_data_i = 8'hAA; s_last_i = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (s_ready_o || mem_req_o) seen = 1'b1;
    end
    s_valid_i = 1'b0; s_last_i = 1'b0;
    chk(tag, 32'(seen), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 s_ready after reset", 32'(s_ready_o), 32'h0);
    chk("R1 mem_req after reset", 32'(mem_req_o), 32'h0);
    chk("R1 irq after reset", 32'(irq_o), 32'h0);

    // four blocks of two buffers, capacity 8, last link terminates
    for (int i = 0; i < 4; i++) begin
      poke(32'h100 + 32'h20 * i, (i == 3) ? 32'h1 : 32'h100 + 32'h20 * (i + 1));
      poke(32'h101 + 32'h20 * i, 32'd8);
      for (int k = 0; k < 2; k++) begin
        poke(32'h102 + 32'h20 * i + 2 * k, 32'h200 + 32'h10 * (2 * i + k));
        poke(32'h103 + 32'h20 * i + 2 * k, 32'h0);
      end
    end
    wr_reg(3'd0, 32'h100);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd2, 32'h102);  // eof-only, two pairs per block
    wr_reg(3'd3, 32'h1);

    // table walk: R2 R3 R4 R5 R8 R9
    b = 0;
    for (int f = 0; f < 6; f++) begin
      send_bytes(f, 0, VEC[f][0], 1'b1);
      repeat (12) @(negedge clk);
      for (int c = 0; c < VEC[f][1]; c++) begin
        int len;
        logic eof;
        len = (VEC[f][0] - 8 * c > 8) ? 8 : VEC[f][0] - 8 * c;
        eof = (c == VEC[f][1] - 1);
        check_buf("R2 R3 R4 R5 R9 table", 32'h103 + 32'h20 * (b / 2) + 2 * (b % 2),
                  32'h200 + 32'h10 * b, f, 8 * c, len, c == 0, eof, eof);
        b++;
      end
    end

    repeat (6) @(negedge clk);
    idle_probe("R6 parked channel idle");

    // extend chain and reload
    poke(32'h180, 32'h1);
    poke(32'h181, 32'd8);
    poke(32'h182, 32'h280);
    poke(32'h183, 32'h0);
    poke(32'h184, 32'h290);
    poke(32'h185, 32'h0);
    poke(32'h160, 32'h180);
    wr_reg(3'd4, 32'h1);
    chk("R10 irq cleared", 32'(irq_o), 32'h0);
    wr_reg(3'd3, 32'h3);
    send_bytes(7, 0, 8, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 no irq without eof", 32'(irq_o), 32'h0);
    check_buf("R7 resumed first buffer", 32'h183, 32'h280, 7, 0, 8, 1'b1, 1'b0, 1'b0);
    send_bytes(7, 8, 4, 1'b1);
    repeat (10) @(negedge clk);
    chk("R10 irq set on eof", 32'(irq_o), 32'h1);
    check_buf("R5 resumed tail buffer", 32'h185, 32'h290, 7, 8, 4, 1'b0, 1'b1, 1'b1);
    wr_reg(3'd4, 32'h1);
    chk("R10 irq clear again", 32'(irq_o), 32'h0);

    // second chain: one pair per block, all buffers interrupt
    wr_reg(3'd3, 32'h0);
    poke(32'h1A0, 32'h1C0);
    poke(32'h1A1, 32'd8);
    poke(32'h1A2, 32'h300);
    poke(32'h1A3, 32'h0);
    poke(32'h1C0, 32'h1);
    poke(32'h1C1, 32'd8);
    poke(32'h1C2, 32'h310);
    poke(32'h1C3, 32'h0);
    wr_reg(3'd0, 32'h1A0);
    wr_reg(3'd2, 32'h001);
    wr_reg(3'd3, 32'h1);
    repeat (10) @(negedge clk);
    wr_reg(3'd3, 32'h0);
    repeat (3) @(negedge clk);
    idle_probe("R11 stopped while waiting");
    chk("R11 no status written", mem[10'h1A3], 32'h0);

    wr_reg(3'd3, 32'h1);
    send_bytes(9, 0, 10, 1'b1);
    repeat (14) @(negedge clk);
    check_buf("R8 R9 one pair first block", 32'h1A3, 32'h300, 9, 0, 8, 1'b1, 1'b0, 1'b1);
    check_buf("R8 one pair second block", 32'h1C3, 32'h310, 9, 8, 2, 1'b0, 1'b1, 1'b1);
    chk("R10 irq after eof-only off", 32'(irq_o), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule